// File: doc/BRIEF.md
# Grouped Deferred Register Commit Buffer

This block sits between the execution datapath and the speculative architectural register file of a processor that runs long scheduled traces split into commit groups. A result produced early, for a group that is not yet the current one, is parked in a numbered slot together with its destination register and its home group. Once that group becomes current, the parked results drain into the register file through a small set of write ports. The block also shares those ports with results that need no parking. At each commit point it holds the pipeline until every slot of the current group has been written. After that it moves to the next group.

Group membership is kept as one bit mask per group rather than by searching slot tags. The slots that may drain in a cycle are the AND of the current group's mask with the pending and ready vectors. A per-group fault vector makes the block leave the trace, rather than enter a group that is already known to be bad. A rollback empties the whole buffer.

Top module: `grp_commit_buf`

## Requirements
- R1: After reset the current group is 0, no write port is enabled, and neither the stall output nor the advance pulse is asserted.
- R2: A slot allocated with its data already present and with the current group as home is driven on write port 0 in the cycle after the allocation, provided no lower-numbered slot is eligible. Port p carries the register on wr_areg bits [6p+5:6p] and the data on wr_data bits [64p+63:64p].
- R3: A slot whose home is a later group is never written while that group is not current. It drains in the first cycle after its group becomes current.
- R4: A data fill for a slot that is waiting for data stores the value and makes the slot ready. The slot drains with the filled value in the next cycle.
- R5: At most 4 parked slots drain per cycle. They are chosen lowest slot index first, occupy ports 0 upward in increasing slot order, and each slot drains only once.
- R6: While a commit point is pending and some slot of the current group has not yet drained, stall is high and the current group holds.
- R7: When a pending commit point finds the current group fully drained, grp_adv is high for that cycle and the current group number increments (wrapping from 15 to 0) at the next edge.
- R8: Direct-commit requests take only the ports left free by parked slots, in ascending request index. dir_gnt shows which requests won; requests that lose are not written.
- R9: A fault reported for a group sets that group's bit in the fault vector. Advancing into a group whose bit is set raises trace_exit for that cycle, returns the current group to 0 and empties the buffer.
- R10: A rollback empties all slots and masks and returns the current group to 0. A later fill to a slot that was pending before the rollback causes no write.
- R11: A fill for a slot that has already drained changes no pending state: it causes no further write of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rollback | input | 1 | Empty the buffer and return to group 0 |
| alloc_vld | input | 1 | Park a result into a slot |
| alloc_slot | input | 7 | Slot index of the parked result |
| alloc_grp | input | 4 | Home group of the parked result |
| alloc_areg | input | 6 | Destination architectural register |
| alloc_rdy | input | 1 | Data is present with the allocation |
| alloc_data | input | 64 | Result data, used when alloc_rdy is high |
| fill_vld | input | 1 | Late data arrival |
| fill_slot | input | 7 | Slot receiving late data |
| fill_data | input | 64 | Late data value |
| dir_vld | input | 4 | Direct-commit requests, one bit per request |
| dir_areg | input | 24 | Direct-commit registers, 6 bits per request |
| dir_data | input | 256 | Direct-commit data, 64 bits per request |
| exc_vld | input | 1 | Mark a group as containing a fault |
| exc_grp | input | 4 | Group to mark |
| commit_pt | input | 1 | Commit point of the current group reached |
| wr_en | output | 4 | Register file write enables |
| wr_areg | output | 24 | Register file write addresses, 6 bits per port |
| wr_data | output | 256 | Register file write data, 64 bits per port |
| dir_gnt | output | 4 | Direct-commit requests that won a port |
| stall | output | 1 | Commit point waiting for the group to drain |
| cur_grp | output | 4 | Current commit group |
| grp_adv | output | 1 | Group advances at the next edge |
| trace_exit | output | 1 | Advancing into a faulted group |

## Verification
The hardest situation to reach from the ports is a commit point that has to wait. This needs a slot of the current group that is still waiting for data, or more than four eligible slots competing for the ports while direct requests also ask for them. Only allocations made without data, plus a flood of ready slots parked for one future group that all become eligible together, produce these. The stimulus builds both cases on purpose: one directed run parks six ready slots in a future group and adds direct requests on the cycles they drain. The random phase allocates about half its slots without data. While a commit point waits, the random phase steers fills towards the current group's pending slots, so stalls start often and always end.

// File: rtl/gcb_pkg.sv
package gcb_pkg;
   localparam int unsigned GCB_SLOTS  = 128;
   localparam int unsigned GCB_GROUPS = 16;
   localparam int unsigned GCB_AREG_W = 6;
   localparam int unsigned GCB_DATA_W = 64;
   localparam int unsigned GCB_PORTS  = 4;

   // successor of a group number, wrapping at the group count
   function automatic int unsigned gcb_next_grp(input int unsigned cur, input int unsigned groups);
      return (cur + 1 >= groups) ? 0 : cur + 1;
   endfunction
endpackage

// File: rtl/gcb_pick.sv
module gcb_pick #(
   parameter int unsigned N = 128,
   parameter int unsigned P = 4,
   localparam int unsigned W = $clog2(N)
) (
   input  logic [N-1:0]   elig,
   output logic [N-1:0]   sel,
   output logic [P-1:0]   vld,
   output logic [P*W-1:0] idx
);
   localparam logic [N-1:0] ONE_N = N'(1);

   logic [N-1:0] rem [P+1];
   assign rem[0] = elig;

   // one stage per port: isolate the lowest set bit, then remove it
   for (genvar p = 0; p < P; p++) begin : g_stage
      logic [N-1:0] low;
      logic [W-1:0] enc;
      assign low        = rem[p] & (~rem[p] + ONE_N);
      assign rem[p+1]   = rem[p] & ~low;
      assign vld[p]     = |rem[p];
      always_comb begin
         enc = '0;
         for (int i = 0; i < N; i++)
            if (low[i]) enc = W'(i);
      end
      assign idx[p*W +: W] = enc;
   end

   assign sel = elig & ~rem[P];

   always_comb begin
      if ($countones(elig) >= P)
         a_r5_pick_count_full: assert ($countones(sel) == P);
      else
         a_r5_pick_count_part: assert ($countones(sel) == $countones(elig));
   end
endmodule

// File: rtl/gcb_slot_store.sv
module gcb_slot_store #(
   parameter int unsigned SLOTS  = 128,
   parameter int unsigned GROUPS = 16,
   parameter int unsigned AREG_W = 6,
   parameter int unsigned DATA_W = 64,
   parameter int unsigned PORTS  = 4,
   localparam int unsigned SW = $clog2(SLOTS),
   localparam int unsigned GW = $clog2(GROUPS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear_all,
   input  logic                   alloc_vld,
   input  logic [SW-1:0]          alloc_slot,
   input  logic [GW-1:0]          alloc_grp,
   input  logic [AREG_W-1:0]      alloc_areg,
   input  logic                   alloc_rdy,
   input  logic [DATA_W-1:0]      alloc_data,
   input  logic                   fill_vld,
   input  logic [SW-1:0]          fill_slot,
   input  logic [DATA_W-1:0]      fill_data,
   input  logic [SLOTS-1:0]       send_vec,
   input  logic                   free_vld,
   input  logic [GW-1:0]          cur_grp,
   output logic [SLOTS-1:0]       elig,
   output logic                   pend_any,
   input  logic [PORTS*SW-1:0]    rd_idx,
   output logic [PORTS*AREG_W-1:0] rd_areg,
   output logic [PORTS*DATA_W-1:0] rd_data
);
   localparam logic [SLOTS-1:0] ONE_S = SLOTS'(1);

   logic [SLOTS-1:0]  c_q, r_q;
   logic [SLOTS-1:0]  mask_q [GROUPS];
   logic [AREG_W-1:0] areg_q [SLOTS];
   logic [DATA_W-1:0] data_q [SLOTS];
   logic [SLOTS-1:0]  cur_mask, alloc_hot, fill_hot, free_vec;

   assign cur_mask  = mask_q[cur_grp];
   assign alloc_hot = alloc_vld ? (ONE_S << alloc_slot) : '0;
   assign fill_hot  = fill_vld  ? (ONE_S << fill_slot)  : '0;
   assign free_vec  = free_vld  ? cur_mask : '0;
   assign elig      = cur_mask & c_q & r_q;
   assign pend_any  = |(cur_mask & c_q);

   // per-slot pending/ready state and payload
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic              c_r, r_r;
      logic [AREG_W-1:0] a_r;
      logic [DATA_W-1:0] d_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_r <= 1'b0;
            r_r <= 1'b0;
         end else if (clear_all) begin
            c_r <= 1'b0;
            r_r <= 1'b0;
         end else if (alloc_hot[s]) begin
            c_r <= 1'b1;
            r_r <= alloc_rdy;
         end else begin
            if (send_vec[s]) c_r <= 1'b0;
            if (fill_hot[s]) r_r <= 1'b1;
            if (free_vec[s]) r_r <= 1'b0;
         end
      end
      always_ff @(posedge clk) begin
         if (alloc_hot[s]) begin
            a_r <= alloc_areg;
            d_r <= alloc_data;
         end else if (fill_hot[s]) begin
            d_r <= fill_data;
         end
      end
      assign c_q[s]    = c_r;
      assign r_q[s]    = r_r;
      assign areg_q[s] = a_r;
      assign data_q[s] = d_r;
   end

   // one membership mask per commit group
   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [SLOTS-1:0] m_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_r <= '0;
         end else if (clear_all) begin
            m_r <= '0;
         end else begin
            if (free_vld && cur_grp == GW'(g)) m_r <= '0;
            if (alloc_vld && alloc_grp == GW'(g)) m_r[alloc_slot] <= 1'b1;
         end
      end
      assign mask_q[g] = m_r;
   end

   for (genvar p = 0; p < PORTS; p++) begin : g_rd
      assign rd_areg[p*AREG_W +: AREG_W] = areg_q[rd_idx[p*SW +: SW]];
      assign rd_data[p*DATA_W +: DATA_W] = data_q[rd_idx[p*SW +: SW]];
   end

   a_r5_sent_once: assert property (@(posedge clk) disable iff (!rst_n)
      (|send_vec) && !clear_all |=> (c_q & $past(send_vec & ~alloc_hot)) == '0);

   a_r11_fill_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
      fill_vld && !clear_all && !alloc_hot[fill_slot] && !send_vec[fill_slot] && !free_vec[fill_slot]
      |=> r_q[$past(fill_slot)] && (c_q[$past(fill_slot)] == $past(c_q[fill_slot])));
endmodule

// File: rtl/gcb_port_arb.sv
module gcb_port_arb #(
   parameter int unsigned P         = 4,
   parameter int unsigned AREG_W    = 6,
   parameter int unsigned DATA_W    = 64,
   parameter bit          DIRECT_EN = 1'b1
) (
   input  logic [P-1:0]        def_vld,
   input  logic [P*AREG_W-1:0] def_areg,
   input  logic [P*DATA_W-1:0] def_data,
   input  logic [P-1:0]        dir_vld,
   input  logic [P*AREG_W-1:0] dir_areg,
   input  logic [P*DATA_W-1:0] dir_data,
   output logic [P-1:0]        wr_en,
   output logic [P*AREG_W-1:0] wr_areg,
   output logic [P*DATA_W-1:0] wr_data,
   output logic [P-1:0]        dir_gnt
);
   localparam int unsigned CW = $clog2(P + 1);

   if (DIRECT_EN) begin : g_share
      // parked slots fill ports from 0; direct requests take what is left
      always_comb begin
         logic [CW-1:0] nxt;
         wr_en   = def_vld;
         wr_areg = '0;
         wr_data = '0;
         dir_gnt = '0;
         nxt     = '0;
         for (int p = 0; p < P; p++) begin
            if (def_vld[p]) begin
               wr_areg[p*AREG_W +: AREG_W] = def_areg[p*AREG_W +: AREG_W];
               wr_data[p*DATA_W +: DATA_W] = def_data[p*DATA_W +: DATA_W];
               nxt = nxt + CW'(1);
            end
         end
         for (int j = 0; j < P; j++) begin
            if (dir_vld[j] && int'(nxt) < P) begin
               dir_gnt[j] = 1'b1;
               wr_en[nxt] = 1'b1;
               wr_areg[nxt*AREG_W +: AREG_W] = dir_areg[j*AREG_W +: AREG_W];
               wr_data[nxt*DATA_W +: DATA_W] = dir_data[j*DATA_W +: DATA_W];
               nxt = nxt + CW'(1);
            end
         end
      end
   end else begin : g_park_only
      always_comb begin
         wr_en   = def_vld;
         wr_areg = '0;
         wr_data = '0;
         dir_gnt = '0;
         for (int p = 0; p < P; p++) begin
            if (def_vld[p]) begin
               wr_areg[p*AREG_W +: AREG_W] = def_areg[p*AREG_W +: AREG_W];
               wr_data[p*DATA_W +: DATA_W] = def_data[p*DATA_W +: DATA_W];
            end
         end
      end
   end

   always_comb begin
      a_r8_ports_fit: assert ($countones(dir_gnt) + $countones(def_vld) <= P);
   end
endmodule

// File: rtl/gcb_grp_ctl.sv
module gcb_grp_ctl
   import gcb_pkg::*;
#(
   parameter int unsigned GROUPS = 16,
   localparam int unsigned GW = $clog2(GROUPS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rollback,
   input  logic          commit_pt,
   input  logic          pend_any,
   input  logic          exc_vld,
   input  logic [GW-1:0] exc_grp,
   output logic [GW-1:0] cur_grp,
   output logic          stall,
   output logic          grp_adv,
   output logic          trace_exit,
   output logic          clear_all
);
   logic [GW-1:0]     cur_q, nxt_grp;
   logic              cpt_q, at_cpt;
   logic [GROUPS-1:0] exc_q;

   assign at_cpt     = commit_pt | cpt_q;
   assign nxt_grp    = GW'(gcb_next_grp(32'(cur_q), GROUPS));
   assign stall      = at_cpt & pend_any;
   assign grp_adv    = at_cpt & ~pend_any & ~rollback;
   assign trace_exit = grp_adv & exc_q[nxt_grp];
   assign clear_all  = rollback | trace_exit;
   assign cur_grp    = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         cpt_q <= 1'b0;
         exc_q <= '0;
      end else if (clear_all) begin
         cur_q <= '0;
         cpt_q <= 1'b0;
         exc_q <= '0;
      end else begin
         if (grp_adv) begin
            cur_q <= nxt_grp;
            cpt_q <= 1'b0;
         end else if (at_cpt) begin
            cpt_q <= 1'b1;
         end
         if (exc_vld) exc_q[exc_grp] <= 1'b1;
      end
   end

   a_r7_adv_step: assert property (@(posedge clk) disable iff (!rst_n)
      grp_adv && !trace_exit |=>
         cur_grp == (($past(cur_grp) == GW'(GROUPS - 1)) ? '0 : $past(cur_grp) + GW'(1)));

   a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall && !rollback |=> $stable(cur_grp));

   a_r9_exit_home: assert property (@(posedge clk) disable iff (!rst_n)
      trace_exit |=> cur_grp == '0);

   a_r10_rb_home: assert property (@(posedge clk) disable iff (!rst_n)
      rollback |=> cur_grp == '0);
endmodule

// File: rtl/grp_commit_buf.sv
module grp_commit_buf
   import gcb_pkg::*;
#(
   parameter int unsigned SLOTS     = GCB_SLOTS,
   parameter int unsigned GROUPS    = GCB_GROUPS,
   parameter int unsigned AREG_W    = GCB_AREG_W,
   parameter int unsigned DATA_W    = GCB_DATA_W,
   parameter int unsigned PORTS     = GCB_PORTS,
   parameter bit          DIRECT_EN = 1'b1,
   localparam int unsigned SW = $clog2(SLOTS),
   localparam int unsigned GW = $clog2(GROUPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rollback,
   input  logic                    alloc_vld,
   input  logic [SW-1:0]           alloc_slot,
   input  logic [GW-1:0]           alloc_grp,
   input  logic [AREG_W-1:0]       alloc_areg,
   input  logic                    alloc_rdy,
   input  logic [DATA_W-1:0]       alloc_data,
   input  logic                    fill_vld,
   input  logic [SW-1:0]           fill_slot,
   input  logic [DATA_W-1:0]       fill_data,
   input  logic [PORTS-1:0]        dir_vld,
   input  logic [PORTS*AREG_W-1:0] dir_areg,
   input  logic [PORTS*DATA_W-1:0] dir_data,
   input  logic                    exc_vld,
   input  logic [GW-1:0]           exc_grp,
   input  logic                    commit_pt,
   output logic [PORTS-1:0]        wr_en,
   output logic [PORTS*AREG_W-1:0] wr_areg,
   output logic [PORTS*DATA_W-1:0] wr_data,
   output logic [PORTS-1:0]        dir_gnt,
   output logic                    stall,
   output logic [GW-1:0]           cur_grp,
   output logic                    grp_adv,
   output logic                    trace_exit
);
   if (SLOTS < 2 || GROUPS < 2) begin : g_bad_size
      $error("grp_commit_buf: SLOTS and GROUPS must be at least 2");
   end
   if (PORTS < 1 || PORTS > SLOTS) begin : g_bad_ports
      $error("grp_commit_buf: PORTS must lie in 1..SLOTS");
   end
   if (AREG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("grp_commit_buf: field widths must be positive");
   end

   logic [SLOTS-1:0]        elig, pick_sel;
   logic [PORTS-1:0]        pick_vld;
   logic [PORTS*SW-1:0]     pick_idx;
   logic [PORTS*AREG_W-1:0] pk_areg;
   logic [PORTS*DATA_W-1:0] pk_data;
   logic                    pend_any, clear_all;

   gcb_grp_ctl #(.GROUPS(GROUPS)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .rollback   (rollback),
      .commit_pt  (commit_pt),
      .pend_any   (pend_any),
      .exc_vld    (exc_vld),
      .exc_grp    (exc_grp),
      .cur_grp    (cur_grp),
      .stall      (stall),
      .grp_adv    (grp_adv),
      .trace_exit (trace_exit),
      .clear_all  (clear_all)
   );

   gcb_slot_store #(
      .SLOTS(SLOTS), .GROUPS(GROUPS), .AREG_W(AREG_W), .DATA_W(DATA_W), .PORTS(PORTS)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_all  (clear_all),
      .alloc_vld  (alloc_vld),
      .alloc_slot (alloc_slot),
      .alloc_grp  (alloc_grp),
      .alloc_areg (alloc_areg),
      .alloc_rdy  (alloc_rdy),
      .alloc_data (alloc_data),
      .fill_vld   (fill_vld),
      .fill_slot  (fill_slot),
      .fill_data  (fill_data),
      .send_vec   (pick_sel),
      .free_vld   (grp_adv),
      .cur_grp    (cur_grp),
      .elig       (elig),
      .pend_any   (pend_any),
      .rd_idx     (pick_idx),
      .rd_areg    (pk_areg),
      .rd_data    (pk_data)
   );

   gcb_pick #(.N(SLOTS), .P(PORTS)) u_pick (
      .elig (elig),
      .sel  (pick_sel),
      .vld  (pick_vld),
      .idx  (pick_idx)
   );

   gcb_port_arb #(
      .P(PORTS), .AREG_W(AREG_W), .DATA_W(DATA_W), .DIRECT_EN(DIRECT_EN)
   ) u_arb (
      .def_vld  (pick_vld),
      .def_areg (pk_areg),
      .def_data (pk_data),
      .dir_vld  (dir_vld),
      .dir_areg (dir_areg),
      .dir_data (dir_data),
      .wr_en    (wr_en),
      .wr_areg  (wr_areg),
      .wr_data  (wr_data),
      .dir_gnt  (dir_gnt)
   );

   a_r10_rb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rollback |=> pick_vld == '0);
endmodule

// File: tb/grp_commit_buf_bench.sv
module grp_commit_buf_bench;
   localparam int NS = 128;
   localparam int NG = 16;
   localparam int NP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          rollback, alloc_vld, alloc_rdy, fill_vld, exc_vld, commit_pt;
   logic [6:0]    alloc_slot, fill_slot;
   logic [3:0]    alloc_grp, exc_grp;
   logic [5:0]    alloc_areg;
   logic [63:0]   alloc_data, fill_data;
   logic [3:0]    dir_vld;
   logic [23:0]   dir_areg;
   logic [255:0]  dir_data;
   logic [3:0]    wr_en, dir_gnt, cur_grp;
   logic [23:0]   wr_areg;
   logic [255:0]  wr_data;
   logic          stall, grp_adv, trace_exit;

   grp_commit_buf u_grp_commit_buf (
      .clk(clk), .rst_n(rst_n), .rollback(rollback),
      .alloc_vld(alloc_vld), .alloc_slot(alloc_slot), .alloc_grp(alloc_grp),
      .alloc_areg(alloc_areg), .alloc_rdy(alloc_rdy), .alloc_data(alloc_data),
      .fill_vld(fill_vld), .fill_slot(fill_slot), .fill_data(fill_data),
      .dir_vld(dir_vld), .dir_areg(dir_areg), .dir_data(dir_data),
      .exc_vld(exc_vld), .exc_grp(exc_grp), .commit_pt(commit_pt),
      .wr_en(wr_en), .wr_areg(wr_areg), .wr_data(wr_data), .dir_gnt(dir_gnt),
      .stall(stall), .cur_grp(cur_grp), .grp_adv(grp_adv), .trace_exit(trace_exit)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference state
   logic [NS-1:0] mC, mR;
   logic [NS-1:0] mM [NG];
   logic [5:0]    mA [NS];
   logic [63:0]   mD [NS];
   int            mCur;
   bit            mPend;
   logic [NG-1:0] mExc;

   // expected outputs for the current cycle
   logic [NS-1:0] eSel;
   logic [3:0]    eEn, eGnt;
   logic [5:0]    eA [NP];
   logic [63:0]   eD [NP];
   bit            eStall, eAdv, eExit;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      mC = '0; mR = '0; mExc = '0; mCur = 0; mPend = 1'b0;
      for (int g = 0; g < NG; g++) mM[g] = '0;
   endtask

   function automatic bit slot_free(input int s);
      for (int g = 0; g < NG; g++) if (mM[g][s]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic calc();
      logic [NS-1:0] el;
      int k;
      int nx;
      el = mM[mCur] & mC & mR;
      eSel = '0; eEn = '0; eGnt = '0; k = 0;
      for (int s = 0; s < NS; s++) begin
         if (el[s] && k < NP) begin
            eSel[s] = 1'b1; eEn[k] = 1'b1; eA[k] = mA[s]; eD[k] = mD[s]; k++;
         end
      end
      for (int j = 0; j < NP; j++) begin
         if (dir_vld[j] && k < NP) begin
            eGnt[j] = 1'b1; eEn[k] = 1'b1;
            eA[k] = dir_areg[j*6 +: 6]; eD[k] = dir_data[j*64 +: 64]; k++;
         end
      end
      nx = (mCur == NG - 1) ? 0 : mCur + 1;
      eStall = (commit_pt || mPend) && (|(mM[mCur] & mC));
      eAdv   = (commit_pt || mPend) && !(|(mM[mCur] & mC)) && !rollback;
      eExit  = eAdv && mExc[nx];
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
      calc();
      chk("R7 cur_grp", 64'(cur_grp), 64'(mCur));
      chk("R6 stall", 64'(stall), 64'(eStall));
      chk("R7 grp_adv", 64'(grp_adv), 64'(eAdv));
      chk("R9 trace_exit", 64'(trace_exit), 64'(eExit));
      chk("R8 dir_gnt", 64'(dir_gnt), 64'(eGnt));
      chk("R5 wr_en", 64'(wr_en), 64'(eEn));
      for (int p = 0; p < NP; p++) begin
         if (eEn[p]) begin
            chk("R5 wr_areg", 64'(wr_areg[p*6 +: 6]), 64'(eA[p]));
            chk("R5 wr_data", wr_data[p*64 +: 64], eD[p]);
         end
      end
   endtask

   task automatic commit();
      @(posedge clk);
      if (rollback || eExit) begin
         model_clear();
      end else begin
         int nx;
         nx = (mCur == NG - 1) ? 0 : mCur + 1;
         mC = mC & ~eSel;
         if (fill_vld) begin mR[fill_slot] = 1'b1; mD[fill_slot] = fill_data; end
         if (eAdv) begin mR = mR & ~mM[mCur]; mM[mCur] = '0; end
         if (alloc_vld) begin
            mC[alloc_slot] = 1'b1; mR[alloc_slot] = alloc_rdy;
            mA[alloc_slot] = alloc_areg; mD[alloc_slot] = alloc_data;
            mM[alloc_grp][alloc_slot] = 1'b1;
         end
         if (eAdv) begin mCur = nx; mPend = 1'b0; end
         else if (commit_pt || mPend) mPend = 1'b1;
         if (exc_vld) mExc[exc_grp] = 1'b1;
      end
      #1;
   endtask

   task automatic idle();
      rollback = 0; alloc_vld = 0; alloc_rdy = 0; fill_vld = 0; exc_vld = 0; commit_pt = 0;
      alloc_slot = '0; fill_slot = '0; alloc_grp = '0; exc_grp = '0; alloc_areg = '0;
      alloc_data = '0; fill_data = '0; dir_vld = '0; dir_areg = '0; dir_data = '0;
   endtask

   task automatic put(input int s, input int g, input int a, input bit rdy, input logic [63:0] d);
      idle();
      alloc_vld = 1; alloc_slot = 7'(s); alloc_grp = 4'(g); alloc_areg = 6'(a);
      alloc_rdy = rdy; alloc_data = d;
   endtask

   task automatic fill(input int s, input logic [63:0] d);
      idle();
      fill_vld = 1; fill_slot = 7'(s); fill_data = d;
   endtask

   task automatic step();
      settle();
      commit();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      idle();
      model_clear();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: state after reset
      settle();
      chk("R1 wr_en", 64'(wr_en), 64'h0);
      chk("R1 cur_grp", 64'(cur_grp), 64'h0);
      chk("R1 stall", 64'(stall), 64'h0);
      chk("R1 grp_adv", 64'(grp_adv), 64'h0);
      commit();

      // R2: ready result for the current group drains next cycle on port 0
      put(5, 0, 7, 1, 64'h1111);
      step();
      idle();
      settle();
      chk("R2 wr_en", 64'(wr_en), 64'h1);
      chk("R2 wr_areg", 64'(wr_areg[5:0]), 64'd7);
      chk("R2 wr_data", wr_data[63:0], 64'h1111);
      commit();

      // R3: future group held until current
      put(9, 1, 9, 1, 64'h2222);
      step();
      idle();
      settle();
      chk("R3 held", 64'(wr_en), 64'h0);
      commit();
      commit_pt = 1;
      settle();
      chk("R7 adv pulse", 64'(grp_adv), 64'h1);
      chk("R7 no stall", 64'(stall), 64'h0);
      commit();
      idle();
      settle();
      chk("R7 incremented", 64'(cur_grp), 64'h1);
      chk("R3 released en", 64'(wr_en), 64'h1);
      chk("R3 released data", wr_data[63:0], 64'h2222);
      commit();

      // R4: late fill
      put(3, 1, 3, 0, 64'h0);
      step();
      idle();
      settle();
      chk("R4 waits", 64'(wr_en), 64'h0);
      commit();
      fill(3, 64'h3333);
      step();
      idle();
      settle();
      chk("R4 en", 64'(wr_en), 64'h1);
      chk("R4 data", wr_data[63:0], 64'h3333);
      chk("R4 areg", 64'(wr_areg[5:0]), 64'd3);
      commit();

      // R11: fill after drain causes no write
      fill(3, 64'h4444);
      step();
      idle();
      settle();
      chk("R11 no rewrite", 64'(wr_en), 64'h0);
      commit();

      // R6: commit point waits for an unready slot
      put(20, 1, 20, 0, 64'h0);
      step();
      idle();
      commit_pt = 1;
      settle();
      chk("R6 stall", 64'(stall), 64'h1);
      chk("R6 no adv", 64'(grp_adv), 64'h0);
      commit();
      idle();
      settle();
      chk("R6 still stall", 64'(stall), 64'h1);
      commit();
      fill(20, 64'h5555);
      step();
      idle();
      settle();
      chk("R6 drain en", 64'(wr_en), 64'h1);
      chk("R6 stall during drain", 64'(stall), 64'h1);
      commit();
      settle();
      chk("R6 released", 64'(stall), 64'h0);
      chk("R6 adv", 64'(grp_adv), 64'h1);
      chk("R6 cur held", 64'(cur_grp), 64'h1);
      commit();

      // R5 and R8: six ready slots in group 3, drained four then two
      begin
         int order [6] = '{120, 50, 11, 10, 4, 2};
         foreach (order[i]) begin
            put(order[i], 3, order[i] % 64, 1, 64'(order[i]));
            step();
         end
      end
      idle();
      commit_pt = 1;
      step();
      idle();
      dir_vld  = 4'b1011;
      dir_areg = {6'd63, 6'd62, 6'd61, 6'd60};
      dir_data = {64'hD3, 64'hD2, 64'hD1, 64'hD0};
      settle();
      chk("R5 four ports", 64'(wr_en), 64'hF);
      chk("R5 port0", wr_data[63:0], 64'd2);
      chk("R5 port1", wr_data[127:64], 64'd4);
      chk("R5 port2", wr_data[191:128], 64'd10);
      chk("R5 port3", wr_data[255:192], 64'd11);
      chk("R8 no grant when full", 64'(dir_gnt), 64'h0);
      commit();
      settle();
      chk("R8 grant", 64'(dir_gnt), 64'h3);
      chk("R5 port0 second", wr_data[63:0], 64'd50);
      chk("R5 port1 second", wr_data[127:64], 64'd120);
      chk("R8 port2 direct", wr_data[191:128], 64'hD0);
      chk("R8 port3 direct", wr_data[255:192], 64'hD1);
      commit();
      idle();
      settle();
      chk("R5 no repeat", 64'(wr_en), 64'h0);
      commit();

      // R9: advancing into a faulted group exits the trace
      exc_vld = 1; exc_grp = 4'd4;
      step();
      idle();
      commit_pt = 1;
      settle();
      chk("R9 exit", 64'(trace_exit), 64'h1);
      commit();
      idle();
      settle();
      chk("R9 back to 0", 64'(cur_grp), 64'h0);
      commit();

      // R10: rollback empties the buffer
      put(7, 0, 7, 0, 64'h0);
      step();
      put(8, 1, 8, 1, 64'h8888);
      step();
      idle();
      rollback = 1;
      step();
      fill(7, 64'h7777);
      step();
      idle();
      commit_pt = 1;
      settle();
      chk("R10 cur", 64'(cur_grp), 64'h0);
      chk("R10 no write", 64'(wr_en), 64'h0);
      chk("R10 no stall", 64'(stall), 64'h0);
      commit();

      // random phase
      for (int n = 0; n < 4000; n++) begin
         idle();
         commit_pt = (!mPend && ($urandom % 8 == 0));
         if ($urandom % 3 != 0) begin
            int s;
            int g;
            s = int'($urandom % NS);
            if (slot_free(s)) begin
               g = (mCur + int'($urandom % 3)) % NG;
               if (g == mCur && (commit_pt || mPend)) g = (mCur + 1) % NG;
               alloc_vld = 1; alloc_slot = 7'(s); alloc_grp = 4'(g);
               alloc_areg = 6'($urandom); alloc_rdy = 1'($urandom);
               alloc_data = {$urandom, $urandom};
            end
         end
         if ($urandom % 3 == 0) begin
            int s;
            s = int'($urandom % NS);
            if (mPend) begin
               for (int t = NS - 1; t >= 0; t--)
                  if (mM[mCur][t] && mC[t] && !mR[t]) s = t;
            end
            if (!(alloc_vld && 7'(s) == alloc_slot)) begin
               fill_vld = 1; fill_slot = 7'(s); fill_data = {$urandom, $urandom};
            end
         end
         dir_vld  = 4'($urandom);
         dir_areg = 24'($urandom);
         dir_data = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
         if ($urandom % 64 == 0) begin
            exc_vld = 1; exc_grp = 4'((mCur + 1 + int'($urandom % 3)) % NG);
         end
         if ($urandom % 300 == 0) rollback = 1;
         step();
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule